// File: doc/BRIEF.md
# Two-Input Handshake Merge Stage

This stage joins two independent producer channels onto a single consumer channel. All three channels use a four-phase, return-to-zero request/acknowledge handshake. There is no select line. Whichever producer raises its request is taken, and its word is captured in an internal register. The stage then acknowledges that producer and presents the captured word downstream with its own request.

If both producers request together, the stage gives the grant to the one that was not served last, so a busy channel cannot lock out the other. A new word is accepted only after the producer and consumer sides of the previous transfer have both returned to zero.

Stages of this kind can be chained into a tree that funnels sparse data to one output. Here the asynchronous timing is modelled with a sampling clock. Every request and acknowledge is seen at a rising edge, and every response is registered.

Top module: `hs_merge2`

## Requirements
- R1: After reset, `a_ack`, `b_ack` and `o_req` are all low.
- R2: When the stage is idle and only one input request is sampled high at a rising edge, the stage does three things at that edge. It raises that input's acknowledge, raises `o_req`, and loads `o_data` with that input's data as sampled at the same edge.
- R3: An input acknowledge stays high while its request stays high. It falls at the first rising edge at which that request is sampled low.
- R4: `o_req` stays high until `o_ack` is sampled high, and falls at that edge. While `o_req` is high, `o_data` does not change.
- R5: No new grant is made until two conditions hold. The consumer has completed `o_ack` low after `o_req` fell, and the previous producer's acknowledge has fallen. The earliest new grant is at the edge after the one at which `o_ack` is sampled low.
- R6: When both requests are sampled high in an idle cycle, the grant goes to the input that was not granted most recently. The first contested grant after reset goes to input A.
- R7: At most one input acknowledge is high at any time. An acknowledge rises only together with the capture of that input's data into `o_data`.
- R8: Changes on `a_data` or `b_data` after the grant have no effect on `o_data` for that transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_req | input | 1 | Request from producer A |
| a_data | input | W | Data from producer A |
| a_ack | output | 1 | Acknowledge to producer A |
| b_req | input | 1 | Request from producer B |
| b_data | input | W | Data from producer B |
| b_ack | output | 1 | Acknowledge to producer B |
| o_req | output | 1 | Request to the consumer |
| o_data | output | W | Captured word for the consumer |
| o_ack | input | 1 | Acknowledge from the consumer |

## Verification
Every response of the stage is due exactly one rising edge after the input that causes it. A grant, with its acknowledge, output request and captured word, follows the request edge by one edge. An acknowledge falls one edge after its request drops, and `o_req` falls one edge after `o_ack` rises. A new grant needs two edges after `o_ack` falls.

The bench changes inputs on falling edges and reads outputs on the next falling edge after the edge that is due. It also checks the edge just before a response, so an early response is caught as well as a late one.

// File: rtl/hs_merge2.sv
module hs_merge2 #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         a_req,
  input  logic [W-1:0] a_data,
  output logic         a_ack,
  input  logic         b_req,
  input  logic [W-1:0] b_data,
  output logic         b_ack,
  output logic         o_req,
  output logic [W-1:0] o_data,
  input  logic         o_ack
);

  typedef enum logic [1:0] {OUT_IDLE, OUT_REQ, OUT_RTZ} out_ph_t;

  out_ph_t      ph;
  logic         last_a;
  logic         ack_a, ack_b;
  logic [W-1:0] hold;

  wire idle  = (ph == OUT_IDLE) && !ack_a && !ack_b;
  wire win_a = idle && a_req && (!b_req || !last_a);
  wire win_b = idle && b_req && (!a_req || last_a);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= OUT_IDLE;
      last_a <= 1'b0;
      ack_a  <= 1'b0;
      ack_b  <= 1'b0;
      hold   <= '0;
    end else begin
      ack_a <= win_a || (ack_a && a_req);
      ack_b <= win_b || (ack_b && b_req);
      if (win_a || win_b) begin
        hold   <= win_a ? a_data : b_data;
        last_a <= win_a;
      end
      case (ph)
        OUT_IDLE: if (win_a || win_b) ph <= OUT_REQ;
        OUT_REQ:  if (o_ack) ph <= OUT_RTZ;
        default:  if (!o_ack) ph <= OUT_IDLE;
      endcase
    end
  end

  assign a_ack  = ack_a;
  assign b_ack  = ack_b;
  assign o_req  = (ph == OUT_REQ);
  assign o_data = hold;

  assert_one_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_ack && b_ack));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_req) |-> (a_ack && o_data == $past(a_data)) ||
                     (b_ack && o_data == $past(b_data)));

  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_req && $past(o_req)) |-> $stable(o_data));

  assert_out_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(o_req) |-> $past(o_ack));

  assert_rtz_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_req) |-> !$past(o_ack));

  assert_ack_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(a_ack) |-> $past(a_req)) and ($rose(b_ack) |-> $past(b_req)));

endmodule

// File: tb/hs_merge2_bench.sv
module hs_merge2_bench;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         a_req = 1'b0, b_req = 1'b0, o_ack = 1'b0;
  logic [W-1:0] a_data = '0, b_data = '0;
  logic         a_ack, b_ack, o_req;
  logic [W-1:0] o_data;

  int errors = 0;
  int checks = 0;
  bit last_b = 1'b1;

  always #2 clk = ~clk;

  hs_merge2 #(.W(W)) u_hs_merge2 (
    .clk(clk), .rst_n(rst_n),
    .a_req(a_req), .a_data(a_data), .a_ack(a_ack),
    .b_req(b_req), .b_data(b_data), .b_ack(b_ack),
    .o_req(o_req), .o_data(o_data), .o_ack(o_ack)
  );

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act,
                     input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pick_b(input int sel, input bit lb);
    if (sel == 1) return 1'b0;
    if (sel == 2) return 1'b1;
    return !lb;
  endfunction

  task automatic expect_grant(input bit sb, input logic [W-1:0] d, input string tag);
    @(negedge clk);
    chk((sb ? b_ack : a_ack) == 1'b1, tag, W'(sb ? b_ack : a_ack), W'(1));
    chk((sb ? a_ack : b_ack) == 1'b0, "R7", W'(sb ? a_ack : b_ack), W'(0));
    chk(o_req == 1'b1, tag, W'(o_req), W'(1));
    chk(o_data == d, tag, o_data, d);
    last_b = sb;
  endtask

  task automatic finish_word(input bit sb, input logic [W-1:0] d);
    int hold_n = $urandom_range(0, 3);
    for (int i = 0; i < hold_n; i++) begin
      if (sb) b_data = W'($urandom); else a_data = W'($urandom);
      @(negedge clk);
      chk((sb ? b_ack : a_ack) == 1'b1, "R3", W'(sb ? b_ack : a_ack), W'(1));
      chk(o_req == 1'b1, "R4", W'(o_req), W'(1));
      chk(o_data == d, "R8", o_data, d);
    end
    if (sb) b_req = 1'b0; else a_req = 1'b0;
    @(negedge clk);
    chk((sb ? b_ack : a_ack) == 1'b0, "R3", W'(sb ? b_ack : a_ack), W'(0));
    chk(o_req == 1'b1, "R4", W'(o_req), W'(1));
    o_ack = 1'b1;
    @(negedge clk);
    chk(o_req == 1'b0, "R4", W'(o_req), W'(0));
    chk(!a_ack && !b_ack, "R5", W'({a_ack, b_ack}), W'(0));
    o_ack = 1'b0;
    @(negedge clk);
    chk(!a_ack && !b_ack && !o_req, "R5", W'({a_ack, b_ack, o_req}), W'(0));
  endtask

  initial begin
    int wd = 0;
    while (wd < 100000) begin
      @(posedge clk);
      wd++;
    end
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk(!a_ack && !b_ack && !o_req, "R1", W'({a_ack, b_ack, o_req}), W'(0));

    a_req = 1'b1; b_req = 1'b1;
    a_data = 16'hA5A5; b_data = 16'h5A5A;
    chk(!a_ack && !b_ack, "R2", W'({a_ack, b_ack}), W'(0));
    expect_grant(1'b0, 16'hA5A5, "R6");
    finish_word(1'b0, 16'hA5A5);
    expect_grant(1'b1, 16'h5A5A, "R6");
    finish_word(1'b1, 16'h5A5A);

    for (int n = 0; n < 60; n++) begin
      int sel = $urandom_range(1, 3);
      bit sb = pick_b(sel, last_b);
      logic [W-1:0] da = W'($urandom);
      logic [W-1:0] db = W'($urandom);
      a_data = da; b_data = db;
      a_req = (sel != 2); b_req = (sel != 1);
      expect_grant(sb, sb ? db : da, sel == 3 ? "R6" : "R2");
      finish_word(sb, sb ? db : da);
      if (sel == 3) begin
        if (sb) a_data = da; else b_data = db;
        expect_grant(!sb, sb ? da : db, "R6");
        finish_word(!sb, sb ? da : db);
      end
      if (n % 7 == 0) begin
        repeat ($urandom_range(1, 4)) begin
          @(negedge clk);
          chk(!a_ack && !b_ack && !o_req, "R2", W'({a_ack, b_ack, o_req}), W'(0));
        end
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule